// File: doc/BRIEF.md
# Pipelined Memory-Backed Bus Slave with Wait States

This block is a single-master bus slave that fronts a small word-organised memory. Each transfer is split into two phases. In the address phase the master presents address and control. In the data phase, which follows, write data or read data moves. The data phase of one transfer runs in the same cycle as the address phase of the next. The slave therefore keeps one pending transfer while the following one is already being driven on the bus.

A parameter sets how many cycles the slave stretches each data phase by holding its ready output low. While ready is low, the master keeps the next address phase on the bus. The slave samples it only once ready returns high. Writes update only the byte lanes selected by the transfer size and the low address bits. Reads return the full 32-bit word, so a read placed straight after a write in the pipeline sees the new data. An address beyond the implemented depth, or a size wider than the data bus, gets a two-cycle error response and has no effect on the memory.

Top module: `pipe_slave`

## Requirements
- R1: While `rst` is high, and in the first cycle after it falls, `ready` is 1 and `resp` is 0.
- R2: Address and control are sampled only in a cycle where `sel` is 1, `ready` is 1 and `trans` is NONSEQ (2'b10) or SEQ (2'b11). IDLE (2'b00), BUSY (2'b01), or `sel` low leave the memory unchanged and give `ready`=1, `resp`=0 in the next cycle.
- R3: A successful transfer's data phase has exactly `WAITS` cycles with `ready`=0 and `resp`=0, followed by one cycle with `ready`=1 and `resp`=0.
- R4: A write takes `wdata` in the last cycle of its data phase. `size` 3'b000 updates byte k = `addr[1:0]`; 3'b001 updates bytes 1:0 when `addr[1]`=0 and bytes 3:2 when it is 1; 3'b010 updates all four. Byte k always comes from `wdata[8k+7:8k]`.
- R5: A read drives the full stored word on `rdata` in the last cycle of its data phase. This includes bytes written by the transfer just before it in the pipeline.
- R6: A transfer whose word index `addr[ADDR_W-1:2]` is `DEPTH` or larger gets one cycle with `ready`=0, `resp`=1, then one cycle with `ready`=1, `resp`=1, whatever the value of `WAITS`. It writes nothing.
- R7: A transfer with `size` above 3'b010 gets the same two-cycle error response as R6 and writes nothing.
- R8: While `ready` is 0, the address and control on the bus are not sampled. A transfer held there is taken in the cycle where `ready` is 1.
- R9: A new transfer is accepted in the last cycle of the previous data phase, so back-to-back transfers need no idle cycle between them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| sel | input | 1 | Slave selected |
| trans | input | 2 | Transfer type: IDLE, BUSY, NONSEQ, SEQ |
| write | input | 1 | 1 = write, 0 = read |
| size | input | 3 | Transfer size: byte, halfword, word |
| addr | input | ADDR_W | Byte address |
| wdata | input | 32 | Write data, valid during data phase |
| rdata | output | 32 | Read data, valid in last data-phase cycle |
| ready | output | 1 | Low stretches the data phase |
| resp | output | 1 | 0 = OKAY, 1 = ERROR |

## Verification
The bench builds three copies of the slave, with `WAITS` set to 0, 1 and 2, and drives the same pipelined stimulus into each.

With zero waits, the write-then-read bypass is exercised under full overlap of the phases. With one and two waits, the master must hold its next address phase through stretched data phases, and the exact length of each stretch is counted. Running the error cases in all three copies shows that the error response keeps its fixed two-cycle shape regardless of the wait setting.

// File: rtl/ahbs_pkg.sv
package ahbs_pkg;

  typedef enum logic [1:0] {
    TR_IDLE = 2'b00,
    TR_BUSY = 2'b01,
    TR_NSEQ = 2'b10,
    TR_SEQ  = 2'b11
  } trans_e;

  // Byte lanes touched by a transfer of the given size at the given offset
  function automatic logic [3:0] lane_mask(input logic [2:0] sz, input logic [1:0] lo);
    case (sz)
      3'd0:    return 4'b0001 << lo;
      3'd1:    return lo[1] ? 4'b1100 : 4'b0011;
      default: return 4'b1111;
    endcase
  endfunction

endpackage

// File: rtl/ahbs_phase.sv
module ahbs_phase
  import ahbs_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DEPTH  = 64,
  parameter int WAITS  = 1
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     sel,
  input  logic [1:0]               trans,
  input  logic                     write,
  input  logic [2:0]               size,
  input  logic [ADDR_W-1:0]        addr,
  output logic                     ready,
  output logic                     resp,
  output logic                     mem_we,
  output logic [$clog2(DEPTH)-1:0] mem_waddr,
  output logic [3:0]               mem_wmask,
  output logic                     mem_re,
  output logic [$clog2(DEPTH)-1:0] mem_raddr
);
  localparam int IDX_W = $clog2(DEPTH);
  localparam int CNT_W = (WAITS < 2) ? 1 : $clog2(WAITS + 1);
  localparam int LAST  = (WAITS > 0) ? WAITS - 1 : 0;

  trans_e           tr;
  logic             accept, bad_range, bad_size, bad_now;
  logic             pend_v, pend_w, pend_err;
  logic [IDX_W-1:0] pend_idx;
  logic [3:0]       pend_mask;
  logic [CNT_W-1:0] cnt;

  assign tr        = trans_e'(trans);
  assign accept    = sel && ready && (tr == TR_NSEQ || tr == TR_SEQ);
  assign bad_range = addr[ADDR_W-1:2] >= (ADDR_W-2)'(DEPTH);
  assign bad_size  = size > 3'd2;
  assign bad_now   = bad_range | bad_size;

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_v    <= 1'b0;
      pend_w    <= 1'b0;
      pend_err  <= 1'b0;
      pend_idx  <= '0;
      pend_mask <= '0;
      cnt       <= '0;
      ready     <= 1'b1;
      resp      <= 1'b0;
    end else if (accept) begin
      pend_v    <= 1'b1;
      pend_w    <= write;
      pend_err  <= bad_now;
      pend_idx  <= addr[IDX_W+1:2];
      pend_mask <= lane_mask(size, addr[1:0]);
      cnt       <= CNT_W'(LAST);
      if (bad_now) begin
        ready <= 1'b0;
        resp  <= 1'b1;
      end else begin
        ready <= (WAITS == 0);
        resp  <= 1'b0;
      end
    end else if (ready) begin
      pend_v <= 1'b0;
      resp   <= 1'b0;
    end else if (pend_err) begin
      ready <= 1'b1;
    end else if (cnt == '0) begin
      ready <= 1'b1;
    end else begin
      cnt <= cnt - 1'b1;
    end
  end

  assign mem_we    = pend_v && ready && pend_w && !pend_err;
  assign mem_waddr = pend_idx;
  assign mem_wmask = pend_mask;
  assign mem_re    = accept && !write;
  assign mem_raddr = addr[IDX_W+1:2];

  // Checker state: length of the current run of OKAY wait cycles
  logic [CNT_W:0] low_run;
  always_ff @(posedge clk) begin
    if (rst) low_run <= '0;
    else     low_run <= (!ready && !resp) ? low_run + 1'b1 : '0;
  end

  // R3
  wait_bound_chk: assert property (@(posedge clk) disable iff (rst)
    low_run <= (CNT_W+1)'(WAITS));
  // R6
  err_second_chk: assert property (@(posedge clk) disable iff (rst)
    (resp && !ready) |=> (resp && ready));
  // R2
  idle_okay_chk: assert property (@(posedge clk) disable iff (rst)
    (ready && !accept) |=> (ready && !resp));
  // R8
  stall_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !ready |=> $stable(pend_idx) && $stable(pend_w));
  // R3
  ok_noerr_chk: assert property (@(posedge clk) disable iff (rst)
    (accept && !bad_now) |=> !resp);
endmodule

// File: rtl/ahbs_mem.sv
module ahbs_mem #(
  parameter int DEPTH = 64
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     we,
  input  logic [3:0]               wmask,
  input  logic [$clog2(DEPTH)-1:0] waddr,
  input  logic [31:0]              wdata,
  input  logic                     re,
  input  logic [$clog2(DEPTH)-1:0] raddr,
  output logic [31:0]              rdata
);
  localparam int LANES = 4;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [7:0] store [DEPTH];
    logic [7:0] rd_q, byp_d;
    logic       byp;

    always_ff @(posedge clk) begin
      if (we && wmask[g]) store[waddr] <= wdata[8*g +: 8];
    end

    always_ff @(posedge clk) begin
      if (re) begin
        rd_q  <= store[raddr];
        byp   <= we && wmask[g] && (waddr == raddr);
        byp_d <= wdata[8*g +: 8];
      end
    end

    assign rdata[8*g +: 8] = byp ? byp_d : rd_q;
  end

  // R4
  wmask_live_chk: assert property (@(posedge clk) disable iff (rst)
    we |-> (wmask != 4'b0000));
endmodule

// File: rtl/pipe_slave.sv
module pipe_slave #(
  parameter int ADDR_W = 16,
  parameter int DEPTH  = 64,
  parameter int WAITS  = 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sel,
  input  logic [1:0]        trans,
  input  logic              write,
  input  logic [2:0]        size,
  input  logic [ADDR_W-1:0] addr,
  input  logic [31:0]       wdata,
  output logic [31:0]       rdata,
  output logic              ready,
  output logic              resp
);
  localparam int IDX_W = $clog2(DEPTH);

  logic             mem_we, mem_re;
  logic [3:0]       mem_wmask;
  logic [IDX_W-1:0] mem_waddr, mem_raddr;

  ahbs_phase #(.ADDR_W(ADDR_W), .DEPTH(DEPTH), .WAITS(WAITS)) u_phase (
    .clk(clk), .rst(rst), .sel(sel), .trans(trans), .write(write),
    .size(size), .addr(addr), .ready(ready), .resp(resp),
    .mem_we(mem_we), .mem_waddr(mem_waddr), .mem_wmask(mem_wmask),
    .mem_re(mem_re), .mem_raddr(mem_raddr)
  );

  ahbs_mem #(.DEPTH(DEPTH)) u_mem (
    .clk(clk), .rst(rst), .we(mem_we), .wmask(mem_wmask), .waddr(mem_waddr),
    .wdata(wdata), .re(mem_re), .raddr(mem_raddr), .rdata(rdata)
  );
endmodule

// File: tb/tb_pipe_slave.sv
module tb_agent #(
  parameter int WAITS = 0
) (
  input  logic clk,
  input  logic rst,
  output logic done,
  output int   nchk,
  output int   nfail
);
  localparam int N = 14;
  // {write, trans, size, addr[15:0], wdata, expected read}
  localparam logic [85:0] VEC [N] = '{
    {1'b1, 2'b10, 3'd2, 16'h0000, 32'hAABBCCDD, 32'h0},
    {1'b1, 2'b11, 3'd2, 16'h0004, 32'h11223344, 32'h0},
    {1'b0, 2'b10, 3'd2, 16'h0000, 32'h0,        32'hAABBCCDD},
    {1'b1, 2'b10, 3'd0, 16'h0005, 32'h0000EE00, 32'h0},
    {1'b0, 2'b10, 3'd2, 16'h0004, 32'h0,        32'h1122EE44},
    {1'b1, 2'b10, 3'd1, 16'h0002, 32'h55660000, 32'h0},
    {1'b1, 2'b10, 3'd2, 16'h0008, 32'h99999999, 32'h0},
    {1'b1, 2'b11, 3'd1, 16'h0008, 32'hFFFF7788, 32'h0},
    {1'b0, 2'b10, 3'd2, 16'h0000, 32'h0,        32'h5566CCDD},
    {1'b1, 2'b10, 3'd0, 16'h000B, 32'h12345678, 32'h0},
    {1'b0, 2'b10, 3'd2, 16'h0008, 32'h0,        32'h12997788},
    {1'b0, 2'b11, 3'd2, 16'h0004, 32'h0,        32'h1122EE44},
    {1'b1, 2'b10, 3'd2, 16'h00FC, 32'hCAFEF00D, 32'h0},
    {1'b0, 2'b10, 3'd2, 16'h00FC, 32'h0,        32'hCAFEF00D}
  };

  logic        sel, write;
  logic [1:0]  trans;
  logic [2:0]  size;
  logic [15:0] addr;
  logic [31:0] wdata, rdata;
  logic        ready, resp;

  pipe_slave #(.ADDR_W(16), .DEPTH(64), .WAITS(WAITS)) dut (
    .clk(clk), .rst(rst), .sel(sel), .trans(trans), .write(write),
    .size(size), .addr(addr), .wdata(wdata), .rdata(rdata),
    .ready(ready), .resp(resp)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s (WAITS=%0d) actual=%h expected=%h", tag, WAITS, act, exp);
    end
  endtask

  task automatic single(input bit w, input logic [2:0] sz, input logic [1:0] tr,
                        input logic [15:0] a, input logic [31:0] d,
                        output int waits, output logic r_first, output logic r_last,
                        output logic [31:0] rd);
    sel = 1'b1; trans = tr; write = w; size = sz; addr = a;
    while (!ready) @(negedge clk);
    @(negedge clk);
    sel = 1'b0; trans = 2'b00; wdata = d;
    waits = 0; r_first = resp;
    while (!ready) begin waits++; @(negedge clk); end
    r_last = resp; rd = rdata;
  endtask

  task automatic read_back(input logic [15:0] a, input logic [31:0] exp, input string tag);
    int wt; logic rf, rl; logic [31:0] rd;
    single(1'b0, 3'd2, 2'b10, a, 32'h0, wt, rf, rl, rd);
    chk(rd === exp && !rl, tag, rd, exp);
  endtask

  initial begin
    int wt; logic rf, rl; logic [31:0] rd;
    done = 0; nchk = 0; nfail = 0;
    sel = 0; trans = 2'b00; write = 0; size = 3'd2; addr = '0; wdata = '0;
    @(negedge clk);
    // R1: state while reset is held
    chk(ready === 1'b1 && resp === 1'b0, "R1 during reset", {30'b0, ready, resp}, 32'h2);
    while (rst) @(negedge clk);
    chk(ready === 1'b1 && resp === 1'b0, "R1 after reset", {30'b0, ready, resp}, 32'h2);

    // Pipelined table walk: R3 R4 R5 R8 R9
    for (int i = 0; i <= N; i++) begin
      if (i < N) begin
        sel = 1'b1; write = VEC[i][85]; trans = VEC[i][84:83];
        size = VEC[i][82:80]; addr = VEC[i][79:64];
      end else begin
        sel = 1'b0; trans = 2'b00;
      end
      if (i > 0) wdata = VEC[i-1][63:32];
      wt = 0;
      while (!ready) begin wt++; @(negedge clk); end
      if (i > 0) begin
        chk(wt == WAITS && !resp, "R3 R8 wait count and OKAY", 32'(wt), 32'(WAITS));
        if (!VEC[i-1][85])
          chk(rdata === VEC[i-1][31:0], "R4 R5 R9 read data", rdata, VEC[i-1][31:0]);
      end
      @(negedge clk);
    end

    // R2: IDLE and BUSY writes leave memory alone
    single(1'b1, 3'd2, 2'b00, 16'h0000, 32'hDEADBEEF, wt, rf, rl, rd);
    chk(wt == 0 && !rl, "R2 IDLE immediate OKAY", 32'(wt), 32'h0);
    single(1'b1, 3'd2, 2'b01, 16'h0000, 32'hDEADBEEF, wt, rf, rl, rd);
    chk(wt == 0 && !rl, "R2 BUSY immediate OKAY", 32'(wt), 32'h0);
    read_back(16'h0000, 32'h5566CCDD, "R2 memory after IDLE/BUSY");
    // R2: NONSEQ write with sel low is not taken
    sel = 1'b0; trans = 2'b10; write = 1'b1; size = 3'd2; addr = 16'h0004; wdata = 32'h0BADF00D;
    @(negedge clk);
    trans = 2'b00;
    @(negedge clk);
    chk(ready === 1'b1 && resp === 1'b0, "R2 deselected OKAY", {30'b0, ready, resp}, 32'h2);
    read_back(16'h0004, 32'h1122EE44, "R2 memory after deselected write");

    // R6: out-of-range write; index 64 would alias word 0 if not blocked
    single(1'b1, 3'd2, 2'b10, 16'h0100, 32'h0BADF00D, wt, rf, rl, rd);
    chk(wt == 1 && rf && rl, "R6 range error shape", {28'(wt), 2'b0, rf, rl}, 32'h13);
    read_back(16'h0000, 32'h5566CCDD, "R6 no write on range error");
    // R7: oversize transfer
    single(1'b1, 3'd3, 2'b10, 16'h0004, 32'h0BADF00D, wt, rf, rl, rd);
    chk(wt == 1 && rf && rl, "R7 size error shape", {28'(wt), 2'b0, rf, rl}, 32'h13);
    read_back(16'h0004, 32'h1122EE44, "R7 no write on size error");
    // R4: upper halfword lanes, then back-to-back read
    single(1'b1, 3'd1, 2'b10, 16'h00FE, 32'h13570000, wt, rf, rl, rd);
    read_back(16'h00FC, 32'h1357F00D, "R4 upper halfword lanes");

    done = 1;
  end
endmodule

module tb_pipe_slave;
  localparam int CLK_PERIOD = 10;
  localparam int LIMIT      = 20000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [2:0] done;
  int nchk [3];
  int nfail [3];
  int cycles = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  for (genvar g = 0; g < 3; g++) begin : g_ag
    tb_agent #(.WAITS(g)) u_ag (
      .clk(clk), .rst(rst), .done(done[g]), .nchk(nchk[g]), .nfail(nfail[g])
    );
  end

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
  end

  always @(posedge clk) cycles <= cycles + 1;

  initial begin
    int tc, tf;
    wait ((&done) || cycles >= LIMIT);
    tc = 0; tf = 0;
    for (int g = 0; g < 3; g++) begin tc += nchk[g]; tf += nfail[g]; end
    if (!(&done)) begin
      tc++; tf++;
      $display("FAIL watchdog R3 handshake actual=%b expected=111", done);
    end
    $display("== %0d vectors applied, %0d miscompares ==", tc, tf);
    $finish;
  end
endmodule